// File: doc/BRIEF.md
# Selectable Serial Line-Code Encoder

This block turns a stream of single data bits into a line level for a recording head or a transmission line. Every bit occupies one cell, and each cell is split into two half-cells of `HALF_CLKS` clock cycles each. A three-bit code select picks one of five line codes. Three of them are plain level codes: level-follows-data, toggle-on-one, and a split-phase code that carries its edge at mid-cell. The other two are frequency-modulation codes: a clocked code that marks every cell boundary, and a modified form of it that marks a boundary only between two zero cells.

A producer offers bits with `in_valid`/`in_data`. The encoder takes a bit only on the clock edge that starts a cell, and flags that edge with `in_ready`. If no bit is offered there, the encoder sends a zero in that cell and raises `underrun` for that cell. The stream runs while `run_en` is high. When `run_en` is low at the end of a cell, the encoder goes idle. The code select is sampled only while idle. Taking a new code clears the line level and the bit history.

The controller has three states. The states are IDLE, FIRST (first half-cell) and SECOND (second half-cell). The transitions are named as follows:
- START: IDLE to FIRST, when `run_en` is high and the code select equals the latched code.
- SWAP: IDLE to IDLE, when the code select differs from the latched code. The new code is latched and the line and history are cleared.
- MID: FIRST to SECOND, at the end of the first half.
- NEXT: SECOND to FIRST, at the end of the second half while `run_en` is high.
- STOP: SECOND to IDLE, at the end of the second half while `run_en` is low.

Top module: `lenc_line_encoder`

## Requirements
- R1: Code 0 (level code): both halves of a cell are driven at the cell's bit value.
- R2: Code 1 (toggle-on-one): the first half is the previous line level XOR the bit, and the second half equals the first half.
- R3: Code 2 (split-phase): the first half is the inverted bit and the second half is the bit. A one therefore rises at mid-cell and a zero falls at mid-cell.
- R4: Code 3 (clocked FM): the first half is the inverse of the previous line level. The second half is the first half XOR the bit.
- R5: Code 4 (modified FM): the first half inverts the previous level only when both the previous cell's bit and this cell's bit are 0. The second half is the first half XOR the bit. The bit history is 1 after reset or after a code change, so no boundary transition is made before the first cell.
- R6: Each half-cell lasts exactly `HALF_CLKS` clock cycles. `second_half` is high during the second half and `cell_active` is high during both halves. The line changes only when a half begins, or on a code change while idle.
- R7: `in_ready` is high only during the clock cycle whose ending edge starts a cell. On that edge a bit is taken when `in_valid` is high. In the cycle after a start, `in_ready` is low.
- R8: If `in_valid` is low at a cell start, that cell carries a 0 and `underrun` is high for the whole cell. A cell that received a bit has `underrun` low.
- R9: A change of the code select while cells are running has no effect on the running stream.
- R10: While idle, a code select that differs from the latched code is latched, drives the line low, and sets the history to 1. No cell starts in that cycle. Selecting the same code again leaves the line unchanged.
- R11: After reset the line is low, the encoder is idle, `underrun` and `in_ready` are low, the history is 1 and the latched code is 0.
- R12: While idle the line holds its last level. Codes 5, 6 and 7 behave exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Keep starting cells while high |
| code_sel | input | 3 | Line code select, latched only while idle |
| in_valid | input | 1 | A data bit is offered |
| in_data | input | 1 | Offered data bit |
| in_ready | output | 1 | The coming edge starts a cell and takes the bit |
| line_out | output | 1 | Encoded line level |
| cell_active | output | 1 | A cell is being sent |
| second_half | output | 1 | The current half-cell is the second one |
| underrun | output | 1 | The current cell received no bit |

## Verification
A corrupted line level or bit history shows up at `line_out` at the next half-cell boundary. In the toggle and FM codes the error then carries into every later cell, because each level is derived from the one before it. A wrong history bit in modified FM shows as a missing or extra boundary edge at the start of the next zero cell. A miscounted half-cell timer shows as a half-cell of the wrong length on `second_half`, within one cell. A code latched at the wrong moment shows as a wrong pattern in the very first cell after the stream starts.

// File: rtl/lenc_pkg.sv
package lenc_pkg;

    localparam int CODE_W = 3;

    // Line code select values
    localparam logic [CODE_W-1:0] CODE_LEVEL  = 3'd0;
    localparam logic [CODE_W-1:0] CODE_TOGGLE = 3'd1;
    localparam logic [CODE_W-1:0] CODE_SPLIT  = 3'd2;
    localparam logic [CODE_W-1:0] CODE_FM     = 3'd3;
    localparam logic [CODE_W-1:0] CODE_MFM    = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } lenc_state_e;

endpackage

// File: rtl/lenc_half_timer.sv
module lenc_half_timer #(
    parameter int HALF_CLKS = 2,
    localparam int CNT_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    output logic [CNT_W-1:0] cnt,
    output logic             half_end
);

    generate
        if (HALF_CLKS == 1) begin : g_single
            // Every clock is a half-cell boundary
            assign cnt      = '0;
            assign half_end = count_en;
        end else begin : g_count
            localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CLKS - 1);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!count_en || cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign cnt      = cnt_q;
            assign half_end = count_en && (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/lenc_level_rules.sv
module lenc_level_rules
    import lenc_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              line_now,
    input  logic              hist_bit,   // bit of the cell before (boundary) / current cell (mid)
    input  logic              new_bit,    // bit entering at the boundary
    output logic              boundary_lvl,
    output logic              mid_lvl
);

    // Level for the first half, chosen at the cell boundary
    always_comb begin
        unique case (code)
            CODE_TOGGLE: boundary_lvl = line_now ^ new_bit;
            CODE_SPLIT:  boundary_lvl = ~new_bit;
            CODE_FM:     boundary_lvl = ~line_now;
            CODE_MFM:    boundary_lvl = line_now ^ (~hist_bit & ~new_bit);
            default:     boundary_lvl = new_bit;
        endcase
    end

    // Level for the second half; hist_bit now holds the current cell's bit
    always_comb begin
        unique case (code)
            CODE_TOGGLE: mid_lvl = line_now;
            CODE_SPLIT:  mid_lvl = hist_bit;
            CODE_FM,
            CODE_MFM:    mid_lvl = line_now ^ hist_bit;
            default:     mid_lvl = hist_bit;
        endcase
    end

endmodule

// File: rtl/lenc_line_encoder.sv
module lenc_line_encoder
    import lenc_pkg::*;
#(
    parameter int HALF_CLKS = 2,
    localparam int CNT_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [CODE_W-1:0] code_sel,
    input  logic              in_valid,
    input  logic              in_data,
    output logic              in_ready,
    output logic              line_out,
    output logic              cell_active,
    output logic              second_half,
    output logic              underrun
);

    lenc_state_e       state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic              line_q;
    logic              hist_q;
    logic              under_q;
    logic [CNT_W-1:0]  half_cnt;
    logic              half_end;
    logic              cell_start;
    logic              code_swap;
    logic              take_bit;
    logic              boundary_lvl;
    logic              mid_lvl;

    lenc_half_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (state_q != ST_IDLE),
        .cnt      (half_cnt),
        .half_end (half_end)
    );

    assign take_bit = in_valid & in_data;

    lenc_level_rules u_rules (
        .code         (code_q),
        .line_now     (line_q),
        .hist_bit     (hist_q),
        .new_bit      (take_bit),
        .boundary_lvl (boundary_lvl),
        .mid_lvl      (mid_lvl)
    );

    // Next-state logic
    always_comb begin
        state_d    = state_q;
        cell_start = 1'b0;
        code_swap  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (code_sel != code_q) begin
                    code_swap = 1'b1;
                end else if (run_en) begin
                    cell_start = 1'b1;
                    state_d    = ST_FIRST;
                end
            end
            ST_FIRST: begin
                if (half_end) state_d = ST_SECOND;
            end
            ST_SECOND: begin
                if (half_end) begin
                    if (run_en) begin
                        cell_start = 1'b1;
                        state_d    = ST_FIRST;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Line, history, code and underrun registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= CODE_LEVEL;
            line_q  <= 1'b0;
            hist_q  <= 1'b1;
            under_q <= 1'b0;
        end else if (code_swap) begin
            code_q <= code_sel;
            line_q <= 1'b0;
            hist_q <= 1'b1;
        end else if (cell_start) begin
            line_q  <= boundary_lvl;
            hist_q  <= take_bit;
            under_q <= ~in_valid;
        end else if (state_q == ST_FIRST && half_end) begin
            line_q <= mid_lvl;
        end else if (state_q == ST_SECOND && half_end) begin
            under_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        in_ready    = cell_start;
        line_out    = line_q;
        cell_active = (state_q != ST_IDLE);
        second_half = (state_q == ST_SECOND);
        underrun    = under_q;
    end

endmodule

// File: rtl/lenc_line_encoder_chk.sv
module lenc_line_encoder_chk
    import lenc_pkg::*;
#(
    parameter int HALF_CLKS = 2,
    localparam int CNT_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic [CODE_W-1:0] code_sel,
    input logic              in_valid,
    input logic              in_ready,
    input logic              line_out,
    input logic              underrun,
    input lenc_state_e       state_q,
    input logic [CODE_W-1:0] code_q,
    input logic [CNT_W-1:0]  half_cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CLKS - 1);

    logic at_half_end;
    assign at_half_end = (state_q != ST_IDLE) && (half_cnt == LAST);

    p_line_moves_at_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_out) |-> (half_cnt == '0));

    p_ready_starts_cell_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> (state_q == ST_FIRST && half_cnt == '0));

    p_ready_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);

    p_underrun_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> underrun);

    p_code_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(code_q));

    p_swap_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && code_sel != code_q) |=> (!line_out && state_q == ST_IDLE));

    p_split_mid_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CODE_SPLIT && state_q == ST_FIRST && at_half_end) |=> (line_out != $past(line_out)));

    p_fm_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CODE_FM && state_q == ST_SECOND && at_half_end && run_en) |=> (line_out != $past(line_out)));

endmodule

bind lenc_line_encoder lenc_line_encoder_chk #(.HALF_CLKS(HALF_CLKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .code_sel (code_sel),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .line_out (line_out),
    .underrun (underrun),
    .state_q  (state_q),
    .code_q   (code_q),
    .half_cnt (half_cnt)
);

// File: tb/lenc_line_encoder_tb.sv
module lenc_line_encoder_tb;

    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [2:0] code_sel = 3'd0;
    logic       in_valid = 1'b0;
    logic       in_data = 1'b0;
    logic       in_ready, line_out, cell_active, second_half, underrun;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lenc_line_encoder #(.HALF_CLKS(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .code_sel(code_sel),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .line_out(line_out), .cell_active(cell_active),
        .second_half(second_half), .underrun(underrun)
    );

    typedef struct {
        logic  f;
        logic  s;
        logic  u;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference model state
    logic [2:0] m_code = 3'd0;
    logic       m_line = 1'b0;
    logic       m_last = 1'b1;

    function automatic string code_tag(input logic [2:0] c);
        case (c)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd0: return "R1";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic expv, input string what);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, expv);
        end
    endtask

    task automatic push_cell(input logic v, input logic d);
        exp_t e;
        logic b;
        logic f;
        logic s;
        b = v & d;
        case (m_code)
            3'd1: begin f = m_line ^ b;              s = f;     end
            3'd2: begin f = ~b;                      s = b;     end
            3'd3: begin f = ~m_line;                 s = f ^ b; end
            3'd4: begin f = m_line ^ (~m_last & ~b); s = f ^ b; end
            default: begin f = b;                    s = b;     end
        endcase
        m_line = s;
        m_last = b;
        e.f = f; e.s = s; e.u = ~v;
        e.tag = v ? code_tag(m_code) : {code_tag(m_code), "/R8"};
        exp_q.push_back(e);
    endtask

    task automatic send_cell(input logic v, input logic d);
        @(negedge clk);
        if (cell_active) begin
            while (!in_ready) @(negedge clk);
        end
        run_en   = 1'b1;
        in_valid = v;
        in_data  = d;
        push_cell(v, d);
        @(posedge clk);
        @(negedge clk);
        check("R7", in_ready, 1'b0, "in_ready after start");
        in_valid = 1'b0;
    endtask

    task automatic stop_run();
        @(negedge clk);
        run_en   = 1'b0;
        in_valid = 1'b0;
        while (cell_active) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_code(input logic [2:0] c);
        @(negedge clk);
        code_sel = c;
        if (c != m_code) begin
            m_code = c;
            m_line = 1'b0;
            m_last = 1'b1;
        end
        repeat (2) @(negedge clk);
    endtask

    // Monitor: samples each half-cell at its first falling edge
    logic f_got, u_got, prev_sh, prev_act;
    int   hc;
    initial begin
        prev_sh = 1'b0; prev_act = 1'b0; hc = 0; f_got = 1'b0; u_got = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                hc++;
                if (cell_active && !second_half && (prev_sh || !prev_act)) begin
                    f_got = line_out;
                    u_got = underrun;
                    hc = 0;
                end
                if (cell_active && second_half && !prev_sh) begin
                    if (exp_q.size() == 0) begin
                        tests++; fails++;
                        $display("FAIL R7 unexpected cell: actual 1 expected 0");
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(e.tag, f_got, e.f, "first half");
                        check(e.tag, line_out, e.s, "second half");
                        check(e.tag, u_got, e.u, "underrun");
                        tests++;
                        if (hc != HALF) begin
                            fails++;
                            $display("FAIL R6 half length: actual %0d expected %0d", hc, HALF);
                        end
                    end
                end
                prev_sh  = second_half;
                prev_act = cell_active;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", line_out, 1'b0, "line at reset");
        check("R11", cell_active, 1'b0, "active at reset");
        check("R11", in_ready, 1'b0, "ready at reset");
        check("R11", underrun, 1'b0, "underrun at reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R11", line_out, 1'b0, "line after release");

        // R1 level code (code 0 from reset)
        send_cell(1, 1); send_cell(1, 0); send_cell(1, 1); send_cell(1, 1);
        stop_run();
        // R12 idle hold
        repeat (5) @(negedge clk);
        check("R12", line_out, m_line, "idle hold");

        // R2 toggle code
        set_code(3'd1);
        send_cell(1, 1); send_cell(1, 1); send_cell(1, 0); send_cell(1, 1);
        send_cell(1, 0); send_cell(1, 0);
        stop_run();
        check("R12", line_out, 1'b1, "idle hold after toggle");

        // R10: same code keeps line, new code clears it
        set_code(3'd1);
        check("R10", line_out, 1'b1, "same code keeps line");
        @(negedge clk);
        code_sel = 3'd2;
        @(negedge clk);
        check("R10", line_out, 1'b0, "code swap clears line");
        check("R10", cell_active, 1'b0, "no start on swap");
        m_code = 3'd2; m_line = 1'b0; m_last = 1'b1;

        // R3 split-phase
        send_cell(1, 1); send_cell(1, 0); send_cell(1, 0); send_cell(1, 1);
        stop_run();

        // R4 clocked FM, with R9 code change mid-run
        set_code(3'd3);
        send_cell(1, 1); send_cell(1, 0);
        code_sel = 3'd0;  // R9: ignored while running
        send_cell(1, 0); send_cell(1, 1); send_cell(1, 1);
        code_sel = 3'd3;
        stop_run();

        // R5 modified FM, with R8 underrun
        set_code(3'd4);
        send_cell(1, 0); send_cell(1, 0); send_cell(1, 1); send_cell(1, 0);
        send_cell(1, 0); send_cell(0, 1); send_cell(1, 1); send_cell(1, 0);
        stop_run();
        check("R8", underrun, 1'b0, "underrun clear when idle");

        // R12 codes 5..7 as code 0
        set_code(3'd6);
        send_cell(1, 1); send_cell(1, 0); send_cell(0, 0); send_cell(1, 1);
        stop_run();

        check("R7", exp_q.size() == 0, 1'b1, "all cells seen");
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule